// File: doc/BRIEF.md
# Hash Engine Input Queue and Key Register Front End

This block sits between a host register bus and a message-digest core. The host writes message data as 64-bit words into a queue that is mapped over a whole window of addresses. Every address in that window reaches the same push end, so a host can stream words with incrementing addresses or hammer one address, and the result is the same. Reads from the window never disturb the queue and always return zero. The core drains the queue through a valid/ready handshake.

The block also holds four 64-bit key registers and a 2-bit algorithm selector. The three digests differ in byte order: the SHA family uses big-endian order and MD5 uses little-endian order. When MD5 is selected, key words are byte-reversed on the way in and on the way out, so the core always sees its native order and a host read returns what the host wrote. A status register gives the queue fill level and a sticky overflow flag.

Host reads are registered: the read data appears on `host_rdata` one clock after the read strobe and holds until the next read.

Top module: `hdg_front`

## Requirements
- R1: After reset `core_valid` is 0, the status word reads 0 (level 0, no overflow) and the algorithm selector reads 00 (MD5).
- R2: A host write to any word address from 0x20 to 0x3F pushes `host_wdata` onto the queue, and words leave in the order they were pushed.
- R3: A host read from any address from 0x20 to 0x3F returns zero and leaves the fill level unchanged.
- R4: The queue holds 16 words. A write into the window while the level is 16 is dropped, even if the core pops in the same cycle, and it sets the overflow flag (status bit 8).
- R5: The overflow flag stays set until the host writes the status address (0x01) with bit 8 at 1. A status write with bit 8 at 0 leaves it set.
- R6: `core_valid` is high exactly when the queue is not empty, `core_data` shows the oldest word, and a cycle with `core_valid` and `core_ready` both high removes that word.
- R7: Status bits [4:0] at address 0x01 give the current fill level from 0 to 16.
- R8: The selector sits at address 0x00, bits [1:0]. 00 selects MD5, 01 selects SHA-1, 10 selects SHA-256, and the reserved code 11 behaves as SHA-256. A read returns the stored code.
- R9: With MD5 selected, a key write at 0x10 to 0x13 stores the word with its eight bytes reversed. A key read reverses the stored bytes again. `core_key` always shows the stored word for the entry picked by `core_key_sel`.
- R10: With code 01, 10 or 11 selected, key words are stored and read back with no byte change.
- R11: Read data appears on `host_rdata` on the clock edge after `host_rd_en`. Addresses that map to no register read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe |
| host_addr | input | 8 | Host word address |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Registered host read data |
| core_valid | output | 1 | Queue holds at least one word |
| core_ready | input | 1 | Core accepts the head word |
| core_data | output | 64 | Head word of the queue |
| core_key_sel | input | 2 | Key entry the core reads |
| core_key | output | 64 | Selected key in the core's native order |

## Verification
The assertions assume that `host_addr` is at a known value whenever a strobe is high. They also assume that the bus gives at most one write per cycle and that `core_ready` has no meaning when `core_valid` is low. The bench changes every input only on the falling clock edge, holds each strobe for exactly one cycle and keeps the address stable around it. The bench raises `core_ready` only after it has seen `core_valid` high, except in the test that overlaps a pop with a write into a full queue. Because of this, the registered read-data and level-step properties never see mid-cycle glitches or overlapping accesses.

// File: rtl/hdg_pkg.sv
package hdg_pkg;
  typedef enum logic [1:0] {
    ALG_MD5    = 2'b00,
    ALG_SHA1   = 2'b01,
    ALG_SHA256 = 2'b10,
    ALG_RSVD   = 2'b11
  } alg_e;

  // Little-endian digest is the only one that needs the key bytes turned around.
  function automatic logic alg_needs_swap(input alg_e a);
    return (a == ALG_MD5);
  endfunction
endpackage

// File: rtl/hdg_decode.sv
module hdg_decode #(
  parameter int ADDR_W    = 8,
  parameter int FIFO_BASE = 32,
  parameter int FIFO_SPAN = 32,
  parameter int KEY_BASE  = 16,
  parameter int NKEYS     = 4,
  parameter int MODE_ADDR = 0,
  parameter int STAT_ADDR = 1,
  localparam int IDX_W    = (NKEYS > 1) ? $clog2(NKEYS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_fifo,
  output logic              hit_key,
  output logic [IDX_W-1:0]  key_idx,
  output logic              hit_mode,
  output logic              hit_stat
);
  localparam logic [ADDR_W:0] FIFO_LO = (ADDR_W+1)'(FIFO_BASE);
  localparam logic [ADDR_W:0] FIFO_HI = (ADDR_W+1)'(FIFO_BASE + FIFO_SPAN);
  localparam logic [ADDR_W:0] KEY_LO  = (ADDR_W+1)'(KEY_BASE);
  localparam logic [ADDR_W:0] KEY_HI  = (ADDR_W+1)'(KEY_BASE + NKEYS);
  localparam logic [ADDR_W:0] MODE_A  = (ADDR_W+1)'(MODE_ADDR);
  localparam logic [ADDR_W:0] STAT_A  = (ADDR_W+1)'(STAT_ADDR);

  logic [ADDR_W:0] a_ext;
  logic [ADDR_W:0] key_off;

  always_comb begin
    a_ext    = {1'b0, addr};
    key_off  = a_ext - KEY_LO;
    hit_fifo = (a_ext >= FIFO_LO) && (a_ext < FIFO_HI);
    hit_key  = (a_ext >= KEY_LO) && (a_ext < KEY_HI);
    key_idx  = key_off[IDX_W-1:0];
    hit_mode = (a_ext == MODE_A);
    hit_stat = (a_ext == STAT_A);
  end

  // R11: each address decodes to at most one region
  always_comb begin
    p_one_region_r11: assert ($onehot0({hit_fifo, hit_key, hit_mode, hit_stat}))
      else $error("address decodes to more than one region");
  end
endmodule

// File: rtl/hdg_fifo.sv
module hdg_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [LVL_W-1:0]  level,
  output logic              drop
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_n;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_n;
  logic [LVL_W-1:0]  cnt_q, cnt_n;
  logic              full, do_push, do_pop;

  always_comb begin
    full     = (cnt_q == FULL_LVL);
    do_push  = push && !full;
    do_pop   = pop_ready && (cnt_q != '0);
    drop     = push && full;
    wr_ptr_n = do_push ? wr_ptr_q + PTR_W'(1) : wr_ptr_q;
    rd_ptr_n = do_pop  ? rd_ptr_q + PTR_W'(1) : rd_ptr_q;
    cnt_n    = cnt_q + LVL_W'(do_push) - LVL_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_n;
      rd_ptr_q <= rd_ptr_n;
      cnt_q    <= cnt_n;
    end
  end

  // Storage needs no reset: a slot is only read after a push has filled it.
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data;
  end

  assign out_valid = (cnt_q != '0);
  assign out_data  = mem_q[rd_ptr_q];
  assign level     = cnt_q;

  p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_LVL);

  p_level_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + LVL_W'(1)
         || cnt_q == $past(cnt_q) - LVL_W'(1)));

  p_drop_keeps_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop_ready) |=> (cnt_q == FULL_LVL));
endmodule

// File: rtl/hdg_keybank.sv
module hdg_keybank
  import hdg_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NKEYS  = 4,
  localparam int IDX_W = (NKEYS > 1) ? $clog2(NKEYS) : 1,
  localparam int BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  alg_e              alg,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  core_idx,
  output logic [DATA_W-1:0] core_key
);
  logic [DATA_W-1:0] key_q [NKEYS];
  logic [DATA_W-1:0] key_n [NKEYS];
  logic [DATA_W-1:0] wr_rev, rd_raw, rd_rev;
  logic              swap;

  assign swap   = alg_needs_swap(alg);
  assign rd_raw = key_q[rd_idx];

  for (genvar b = 0; b < BYTES; b++) begin : g_rev
    assign wr_rev[8*b +: 8] = wr_data[8*(BYTES-1-b) +: 8];
    assign rd_rev[8*b +: 8] = rd_raw[8*(BYTES-1-b) +: 8];
  end

  always_comb begin
    for (int k = 0; k < NKEYS; k++) begin
      key_n[k] = key_q[k];
      if (wr_en && (wr_idx == IDX_W'(k)))
        key_n[k] = swap ? wr_rev : wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NKEYS; k++) key_q[k] <= '0;
    end else begin
      for (int k = 0; k < NKEYS; k++) key_q[k] <= key_n[k];
    end
  end

  assign rd_data  = swap ? rd_rev : rd_raw;
  assign core_key = key_q[core_idx];

  // R9/R10: with the same algorithm, the host reads back exactly what it wrote
  p_key_roundtrip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_idx == $past(wr_idx) && alg == $past(alg))
               -> rd_data == $past(wr_data)));
endmodule

// File: rtl/hdg_front.sv
module hdg_front
  import hdg_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 8,
  parameter int DEPTH     = 16,
  parameter int NKEYS     = 4,
  parameter int FIFO_BASE = 32,
  parameter int FIFO_SPAN = 32,
  parameter int KEY_BASE  = 16,
  parameter int MODE_ADDR = 0,
  parameter int STAT_ADDR = 1,
  parameter int OVF_BIT   = 8,
  localparam int IDX_W    = (NKEYS > 1) ? $clog2(NKEYS) : 1,
  localparam int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              core_valid,
  input  logic              core_ready,
  output logic [DATA_W-1:0] core_data,
  input  logic [IDX_W-1:0]  core_key_sel,
  output logic [DATA_W-1:0] core_key
);
  logic              hit_fifo, hit_key, hit_mode, hit_stat;
  logic [IDX_W-1:0]  key_idx;
  logic [LVL_W-1:0]  level;
  logic              drop;
  logic [DATA_W-1:0] key_rd;
  logic [DATA_W-1:0] stat_word;
  logic              ovf_clr;

  alg_e              mode_q, mode_n;
  logic              ovf_q, ovf_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;

  hdg_decode #(
    .ADDR_W(ADDR_W), .FIFO_BASE(FIFO_BASE), .FIFO_SPAN(FIFO_SPAN),
    .KEY_BASE(KEY_BASE), .NKEYS(NKEYS), .MODE_ADDR(MODE_ADDR), .STAT_ADDR(STAT_ADDR)
  ) dec_i (
    .addr(host_addr), .hit_fifo(hit_fifo), .hit_key(hit_key),
    .key_idx(key_idx), .hit_mode(hit_mode), .hit_stat(hit_stat)
  );

  hdg_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(host_wr_en && hit_fifo), .push_data(host_wdata),
    .pop_ready(core_ready), .out_valid(core_valid), .out_data(core_data),
    .level(level), .drop(drop)
  );

  hdg_keybank #(.DATA_W(DATA_W), .NKEYS(NKEYS)) keys_i (
    .clk(clk), .rst_n(rst_n), .alg(mode_q),
    .wr_en(host_wr_en && hit_key), .wr_idx(key_idx), .wr_data(host_wdata),
    .rd_idx(key_idx), .rd_data(key_rd),
    .core_idx(core_key_sel), .core_key(core_key)
  );

  always_comb begin
    ovf_clr = host_wr_en && hit_stat && host_wdata[OVF_BIT];
    // A drop in the same cycle as a clear wins: the new overflow is not lost.
    ovf_n   = drop || (ovf_q && !ovf_clr);
    mode_n  = (host_wr_en && hit_mode) ? alg_e'(host_wdata[1:0]) : mode_q;

    stat_word             = '0;
    stat_word[LVL_W-1:0]  = level;
    stat_word[OVF_BIT]    = ovf_q;

    rdata_n = rdata_q;
    if (host_rd_en) begin
      if (hit_key)       rdata_n = key_rd;
      else if (hit_mode) rdata_n = {{(DATA_W-2){1'b0}}, mode_q};
      else if (hit_stat) rdata_n = stat_word;
      else               rdata_n = '0;   // queue window and unmapped space
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= ALG_MD5;
      ovf_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      mode_q  <= mode_n;
      ovf_q   <= ovf_n;
      rdata_q <= rdata_n;
    end
  end

  assign host_rdata = rdata_q;

  p_window_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && hit_fifo) |=> (host_rdata == '0));

  p_read_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_en && !host_wr_en && !(core_valid && core_ready)) |=> $stable(level));

  p_drop_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovf_q);

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(host_wr_en && hit_stat && host_wdata[OVF_BIT])) |=> ovf_q);

  p_valid_tracks_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid == (level != '0));
endmodule

// File: tb/hdg_front_tb_top.sv
module hdg_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr_en, host_rd_en;
  logic [7:0]  host_addr;
  logic [63:0] host_wdata, host_rdata;
  logic        core_valid, core_ready;
  logic [63:0] core_data;
  logic [1:0]  core_key_sel;
  logic [63:0] core_key;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  hdg_front dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .core_valid(core_valid), .core_ready(core_ready), .core_data(core_data),
    .core_key_sel(core_key_sel), .core_key(core_key)
  );

  // Vector table: op 1 = write, op 0 = read and compare; tag = requirement number.
  localparam int NV = 11;
  localparam logic       VOP  [NV] = '{1, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0};
  localparam logic [7:0] VADR [NV] = '{8'h00, 8'h10, 8'h10, 8'h00, 8'h10,
                                       8'h11, 8'h11, 8'h00, 8'h25, 8'h7F, 8'h02};
  localparam logic [63:0] VDAT [NV] = '{
    64'h0,                   // select MD5
    64'h0011223344556677,    // key0 written in MD5
    64'h0011223344556677,    // R9 read returns what was written
    64'h1,                   // select SHA-1
    64'h7766554433221100,    // R10 stored reversed word passes unchanged
    64'hA1A2A3A4A5A6A7A8,    // key1 written in SHA-1
    64'hA1A2A3A4A5A6A7A8,    // R10
    64'h1,                   // R8 mode readback
    64'h0,                   // R3 window read
    64'h0,                   // R11 unmapped
    64'h0                    // R11 unmapped
  };
  localparam int VREQ [NV] = '{8, 9, 9, 8, 10, 10, 10, 8, 3, 11, 11};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr_en = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    host_addr = a; host_rd_en = 1'b1;
    @(negedge clk);
    host_rd_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic pop_chk(input string req, input logic [63:0] exp);
    @(negedge clk);
    chk(req, {63'b0, core_valid}, 64'h1);
    chk(req, core_data, exp);
    core_ready = 1'b1;
    @(negedge clk);
    core_ready = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] r;
    rst_n = 1'b0; host_wr_en = 1'b0; host_rd_en = 1'b0; host_addr = '0;
    host_wdata = '0; core_ready = 1'b0; core_key_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 valid", {63'b0, core_valid}, 64'h0);
    rd(8'h01, r); chk("R1 status", r, 64'h0);
    rd(8'h00, r); chk("R1 mode", r, 64'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VOP[i]) wr(VADR[i], VDAT[i]);
      else begin
        rd(VADR[i], r);
        chk($sformatf("R%0d vec%0d", VREQ[i], i), r, VDAT[i]);
      end
    end

    // R9 core sees the byte-reversed key written under MD5; R10 key1 unchanged
    @(negedge clk); core_key_sel = 2'd0;
    @(negedge clk); chk("R9 core key0", core_key, 64'h7766554433221100);
    core_key_sel = 2'd1;
    @(negedge clk); chk("R10 core key1", core_key, 64'hA1A2A3A4A5A6A7A8);

    // R8/R10 reserved code 11 behaves as SHA-256: no swap
    wr(8'h00, 64'h3);
    rd(8'h00, r); chk("R8 reserved code", r, 64'h3);
    wr(8'h12, 64'hDEADBEEF01234567);
    @(negedge clk); core_key_sel = 2'd2;
    @(negedge clk); chk("R10 code11 core", core_key, 64'hDEADBEEF01234567);
    // R9 MD5 write to last key entry
    wr(8'h00, 64'h0);
    wr(8'h13, 64'h0102030405060708);
    core_key_sel = 2'd3;
    @(negedge clk); chk("R9 core key3", core_key, 64'h0807060504030201);
    rd(8'h13, r); chk("R9 key3 read", r, 64'h0102030405060708);

    // R2 aliased pushes, R3 window read, R7 level, R6 order
    wr(8'h20, 64'h1111); wr(8'h3F, 64'h2222); wr(8'h2A, 64'h3333);
    rd(8'h01, r); chk("R7 level 3", r, 64'h3);
    rd(8'h31, r); chk("R3 window read", r, 64'h0);
    rd(8'h01, r); chk("R3 level kept", r, 64'h3);
    pop_chk("R2 first", 64'h1111);
    pop_chk("R2 second", 64'h2222);
    pop_chk("R6 third", 64'h3333);
    @(negedge clk); chk("R6 empty", {63'b0, core_valid}, 64'h0);

    // R4 overflow: 17 writes, the last dropped
    for (int i = 0; i < 17; i++) wr(8'h20 + 8'(i), 64'h100 + 64'(i));
    rd(8'h01, r); chk("R4 full+ovf", r, 64'h110);
    // R5 writing 0 to bit 8 keeps flag; 1 clears
    wr(8'h01, 64'h0);
    rd(8'h01, r); chk("R5 sticky", r, 64'h110);
    wr(8'h01, 64'h100);
    rd(8'h01, r); chk("R5 cleared", r, 64'h010);

    // R4 push while full with a pop in the same cycle: still dropped
    @(negedge clk);
    host_addr = 8'h22; host_wdata = 64'hBAD; host_wr_en = 1'b1; core_ready = 1'b1;
    @(negedge clk);
    host_wr_en = 1'b0; core_ready = 1'b0;
    rd(8'h01, r); chk("R4 drop with pop", r, 64'h10F);
    for (int i = 1; i < 16; i++) pop_chk("R4 drained order", 64'h100 + 64'(i));
    @(negedge clk); chk("R4 no dropped word", {63'b0, core_valid}, 64'h0);

    // R1 reset mid-run
    wr(8'h20, 64'h55); wr(8'h00, 64'h2);
    do_reset();
    @(negedge clk);
    chk("R1 valid after reset", {63'b0, core_valid}, 64'h0);
    rd(8'h01, r); chk("R1 status after reset", r, 64'h0);
    rd(8'h00, r); chk("R1 mode after reset", r, 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule